// File: doc/BRIEF.md
# Watchdog countdown timer

This block is a memory-mapped watchdog. At its core is a down-counter, 32 bits wide by default. Software stores a reload value and then arms the counter by writing an exact 16-bit restart word to a dedicated kick register. While the run bit is set, the counter steps down. It steps either on every clock or only on clocks where an external 1 MHz tick-enable input is high. When it falls from one to zero, the block produces its expiry actions, and each action has its own control bit:

- a one-cycle system-reset request;
- a one-cycle trigger for the external signal;
- a sticky interrupt flag.

After expiry the counter stays at zero until software kicks it again. A two-bit reset-mode field in the control register is driven straight out beside the reset request. Pulse shaping and the distribution of the reset are left to logic outside this block.

The register port is a plain single-cycle write strobe with an address and data, plus combinational read data for the current address. It takes one access per clock and never applies back-pressure. No data stream enters or leaves the block, so there is no valid/ready handshake. A typical start sequence has four writes in this order: control to zero, the reload value, the restart word, then control with the run bit set.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register, the reload register and the counter all read zero, and irq_o, sys_rst_req_o and ext_trig_o are low.
- R2: Byte offset 0x4 holds the reload value and reads back what was written. Offset 0xC holds control bits 6:0 and reads back those bits, with bits 31:7 reading zero. Offset 0x8 always reads zero. Offset 0x0 reads the live counter.
- R3: A write of exactly 0x00004755 to offset 0x8 copies the reload register into the counter on that clock edge.
- R4: Any other value written to offset 0x8 leaves the counter unchanged, including a value whose low 16 bits are 0x4755 but whose upper bits are not zero.
- R5: With control bit 0 (run) set and control bit 4 (slow tick) clear, a nonzero counter decrements by one on every clock, whatever tick_1us_i does.
- R6: With run set and slow tick set, a nonzero counter decrements only on clocks where tick_1us_i is high.
- R7: With run clear, the counter holds its value.
- R8: When the counter steps from 1 to 0 with run set, the outputs change from the next cycle. sys_rst_req_o pulses high for exactly one cycle if control bit 1 is set. ext_trig_o pulses high for exactly one cycle if control bit 3 is set. Neither pulses if its bit is clear. The counter then stays at 0 until a restart.
- R9: On that same expiry, irq_o goes high if control bit 2 is set and stays high. It is cleared by a valid restart write or by a control write with bit 0 clear.
- R10: rst_mode_o always equals control bits 6:5. Code 0 means SoC reset and code 1 means full-chip reset.
- R11: When a valid restart write lands on a clock where the counter would otherwise decrement, the counter takes the reload value and does not take the decremented value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us_i | input | 1 | Active-high 1 MHz tick enable, sampled every clock |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Byte offset for reads and writes |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Sticky expiry interrupt |
| sys_rst_req_o | output | 1 | One-cycle system-reset request on expiry |
| ext_trig_o | output | 1 | One-cycle external-signal trigger on expiry |
| rst_mode_o | output | 2 | Reset-mode code from control bits 6:5 |

## Verification
The countdown is exercised from several reload values with three stepping conditions:

- the fast clock, where the tick pattern must have no effect;
- the slow tick, using sparse patterns of period three and five;
- run cleared.

Comparing the counts read after a fixed number of clocks separates these cases. All-ones and small reload values show wrap-free counting and saturation at zero. Expiry is run once with every action enabled and once with none enabled, which shows both the per-action gating and the one-cycle pulse width. Restart writes are also tried with near-miss words, again while an expiry flag is pending, and on a clock where the counter is decrementing; these cases separate exact matching, the two ways of clearing the flag, and restart priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Byte offsets of the register slots.
  localparam logic [3:0] OFS_COUNT  = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_KICK   = 4'h8;
  localparam logic [3:0] OFS_CTRL   = 4'hC;

  // Restart word that arms the counter.
  localparam logic [15:0] KICK_WORD = 16'h4755;

  // Control register, bit 0 at the bottom.
  typedef struct packed {
    logic [1:0] mode;      // 6:5 reset-mode code
    logic       slow_tick; // 4   step on the 1 MHz enable
    logic       ext_en;    // 3   external trigger on expiry
    logic       irq_en;    // 2   interrupt on expiry
    logic       rst_en;    // 1   reset request on expiry
    logic       run;       // 0   counting enabled
  } wd_ctrl_t;

  localparam int CTRL_W = $bits(wd_ctrl_t);
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [3:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output wd_ctrl_t          ctrl_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              kick_o,
  output logic              halt_wr_o
);
  localparam logic [DATA_W-1:0] KICK_FULL = DATA_W'(KICK_WORD);

  wd_ctrl_t         ctrl_q;
  logic [CNT_W-1:0] reload_q;

  // A restart needs the whole word to match, upper bits included.
  assign kick_o    = wr_i && (addr_i == OFS_KICK) && (wdata_i == KICK_FULL);
  assign halt_wr_o = wr_i && (addr_i == OFS_CTRL) && !wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_CTRL)   ctrl_q   <= wd_ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (addr_i == OFS_RELOAD) reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick (
  input  logic slow_sel_i,
  input  logic tick_i,
  output logic step_o
);
  // Fast mode steps on every clock; slow mode waits for the tick enable.
  assign step_o = slow_sel_i ? tick_i : 1'b1;
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             step_i,
  input  logic             kick_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             rst_en_i,
  input  logic             irq_en_i,
  input  logic             ext_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             sys_rst_o,
  output logic             ext_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, sys_rst_q, ext_q;
  logic             advance, expire;

  assign advance = run_i && step_i && (cnt_q != '0);
  assign expire  = advance && !kick_i && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      sys_rst_q <= 1'b0;
      ext_q     <= 1'b0;
    end else begin
      if (kick_i)       cnt_q <= reload_i;
      else if (advance) cnt_q <= cnt_q - ONE;

      sys_rst_q <= expire && rst_en_i;
      ext_q     <= expire && ext_en_i;

      if (kick_i || halt_i)        irq_q <= 1'b0;
      else if (expire && irq_en_i) irq_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign sys_rst_o = sys_rst_q;
  assign ext_o     = ext_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us_i,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              sys_rst_req_o,
  output logic              ext_trig_o,
  output logic [1:0]        rst_mode_o
);
  wd_ctrl_t          ctrl_q;
  logic [CTRL_W-1:0] ctrl_bits;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              kick, halt_wr, step;

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl_q),
    .reload_o  (reload_q),
    .kick_o    (kick),
    .halt_wr_o (halt_wr)
  );

  wdog_tick u_tick (
    .slow_sel_i (ctrl_q.slow_tick),
    .tick_i     (tick_1us_i),
    .step_o     (step)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ctrl_q.run),
    .step_i    (step),
    .kick_i    (kick),
    .halt_i    (halt_wr),
    .reload_i  (reload_q),
    .rst_en_i  (ctrl_q.rst_en),
    .irq_en_i  (ctrl_q.irq_en),
    .ext_en_i  (ctrl_q.ext_en),
    .cnt_o     (cnt_q),
    .irq_o     (irq_o),
    .sys_rst_o (sys_rst_req_o),
    .ext_o     (ext_trig_o)
  );

  assign ctrl_bits  = ctrl_q;
  assign rst_mode_o = ctrl_q.mode;

  always_comb begin
    case (reg_addr_i)
      OFS_COUNT:  reg_rdata_o = DATA_W'(cnt_q);
      OFS_RELOAD: reg_rdata_o = DATA_W'(reload_q);
      OFS_CTRL:   reg_rdata_o = DATA_W'(ctrl_bits);
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer_checks.sv
module wdog_timer_checks
  import wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [3:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              run,
  input logic              slow,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  reload,
  input logic              irq_o,
  input logic              sys_rst_req_o,
  input logic              ext_trig_o
);
  logic kick_seen, halt_seen;
  assign kick_seen = reg_wr_i && (reg_addr_i == OFS_KICK) &&
                     (reg_wdata_i == DATA_W'(KICK_WORD));
  assign halt_seen = reg_wr_i && (reg_addr_i == OFS_CTRL) && !reg_wdata_i[0];

  assert_kick_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_seen |=> cnt == $past(reload));

  assert_fast_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !slow && cnt != '0 && !kick_seen) |=> cnt == $past(cnt) - CNT_W'(1));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !kick_seen) |=> $stable(cnt));

  assert_rst_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req_o |=> !sys_rst_req_o);

  assert_ext_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_trig_o |=> !ext_trig_o);

  assert_rst_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req_o) |-> cnt == '0);

  assert_zero_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !kick_seen) |=> cnt == '0);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !kick_seen && !halt_seen) |=> irq_o);
endmodule

bind wdog_timer wdog_timer_checks #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_i      (reg_wr_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .run           (ctrl_q.run),
  .slow          (ctrl_q.slow_tick),
  .cnt           (cnt_q),
  .reload        (reload_q),
  .irq_o         (irq_o),
  .sys_rst_req_o (sys_rst_req_o),
  .ext_trig_o    (ext_trig_o)
);

// File: tb/sim_wdog_timer.sv
`timescale 1ns/1ps
module sim_wdog_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, sysr, ext;
  logic [1:0]  mode;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdog_timer u0 (
    .clk (clk), .rst_n (rst_n), .tick_1us_i (tick),
    .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq), .sys_rst_req_o (sysr),
    .ext_trig_o (ext), .rst_mode_o (mode)
  );

  // Vector table: reload, control, tick period, clocks run, expected count.
  localparam int NV = 7;
  localparam logic [31:0] VR [NV] = '{32'd100, 32'd100, 32'd100, 32'd100, 32'd5, 32'hFFFF_FFFF, 32'd50};
  localparam logic [31:0] VC [NV] = '{32'h01, 32'h11, 32'h11, 32'h00, 32'h01, 32'h01, 32'h11};
  localparam int          VP [NV] = '{3, 3, 1, 3, 3, 3, 5};
  localparam int          VK [NV] = '{10, 10, 10, 10, 10, 3, 20};
  localparam logic [31:0] VE [NV] = '{32'd90, 32'd96, 32'd90, 32'd100, 32'd0, 32'hFFFF_FFFC, 32'd46};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic arm(input logic [31:0] rl, input logic [31:0] c);
    wreg(4'hC, 32'h0);
    wreg(4'h4, rl);
    wreg(4'h8, 32'h0000_4755);
    wreg(4'hC, c);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic any;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rreg(4'h0, d); chk("R1 counter", d, 32'h0);
    rreg(4'h4, d); chk("R1 reload", d, 32'h0);
    rreg(4'hC, d); chk("R1 control", d, 32'h0);
    chk("R1 outputs", {29'b0, irq, sysr, ext}, 32'h0);

    // R2 read-back, R10 mode pass-through
    wreg(4'h4, 32'h1234_5678);
    rreg(4'h4, d); chk("R2 reload readback", d, 32'h1234_5678);
    wreg(4'hC, 32'h7E);
    rreg(4'hC, d); chk("R2 control readback", d, 32'h7E);
    chk("R10 mode 3", {30'b0, mode}, 32'd3);
    wreg(4'hC, 32'h20);
    chk("R10 mode 1", {30'b0, mode}, 32'd1);
    wreg(4'hC, 32'hFFFF_FF80);
    rreg(4'hC, d); chk("R2 control upper bits", d, 32'h0);
    rreg(4'h8, d); chk("R2 kick reads zero", d, 32'h0);

    // R3 restart loads, R4 near-miss words ignored
    wreg(4'h4, 32'd40);
    wreg(4'h8, 32'h0000_4755);
    rreg(4'h0, d); chk("R3 restart load", d, 32'd40);
    wreg(4'h4, 32'd77);
    wreg(4'h8, 32'h0000_4756);
    rreg(4'h0, d); chk("R4 wrong word", d, 32'd40);
    wreg(4'h8, 32'h0001_4755);
    rreg(4'h0, d); chk("R4 upper bits set", d, 32'd40);

    // Table walk: R5 fast, R6 slow tick, R7 halted, R8 saturate
    for (int v = 0; v < NV; v++) begin
      arm(VR[v], VC[v]);
      for (int i = 0; i < VK[v]; i++) begin
        tick = (i % VP[v]) == 0;
        @(negedge clk);
      end
      tick = 1'b0;
      rreg(4'h0, d);
      chk($sformatf("R5/R6/R7 vector %0d", v), d, VE[v]);
    end

    // R8 expiry with all actions, R9 sticky interrupt
    arm(32'd3, 32'h0F);
    addr = 4'h0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 no pulse before expiry", {30'b0, sysr, ext}, 32'h0);
    chk("R8 count one", rdata, 32'd1);
    @(negedge clk);
    chk("R8 pulses at expiry", {29'b0, irq, sysr, ext}, 32'h7);
    chk("R8 count zero", rdata, 32'd0);
    @(negedge clk);
    chk("R8 pulse one cycle", {30'b0, sysr, ext}, 32'h0);
    repeat (5) @(negedge clk);
    chk("R9 irq sticky", {31'b0, irq}, 32'h1);
    chk("R8 holds zero", rdata, 32'd0);
    wreg(4'h8, 32'h0000_4755);
    chk("R9 cleared by restart", {31'b0, irq}, 32'h0);
    repeat (4) @(negedge clk);
    chk("R9 set again", {31'b0, irq}, 32'h1);
    wreg(4'hC, 32'h0E);
    chk("R9 cleared by halt write", {31'b0, irq}, 32'h0);

    // R8 gating: expiry with no actions enabled
    arm(32'd2, 32'h01);
    any = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      any = any | irq | sysr | ext;
    end
    chk("R8 actions gated off", {31'b0, any}, 32'h0);
    rreg(4'h0, d); chk("R8 gated count zero", d, 32'd0);

    // R11 restart wins over decrement
    arm(32'd1000, 32'h01);
    repeat (5) @(negedge clk);
    rreg(4'h0, d); chk("R5 running count", d, 32'd995);
    wreg(4'h8, 32'h0000_4755);
    rreg(4'h0, d); chk("R11 restart priority", d, 32'd1000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule